// File: doc/BRIEF.md
# Digital Gain, Offset and Clamp Stage

This block sits in a converter channel, between the sample source and the converter. It scales each 14-bit two's-complement sample by a signed gain and adds a signed offset. The result is clamped to the 14-bit code range, so it never wraps.

The gain is a 12-bit two's-complement code with ten fractional bits, covering -2 to just under +2. The code 0x400 means unity. The scaled product is truncated toward negative infinity before the offset is added. A code of 0 is mid-scale at the converter.

The stage is a two-register pipeline with a valid flag. Gain and offset are static register values, sampled together with each valid sample.

Top module: `gain_offset_clamp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `validOut` is 0 and `dataOut` is 0.
- R2: A sample accepted with `validIn`=1 at a rising edge appears on `dataOut`, with `validOut`=1, after the second rising edge that follows. `validOut` is 1 only in that cycle for that sample, and back-to-back samples stream out in the same order.
- R3: With `gainCode`=0x400 and `offsetIn`=0, `dataOut` equals the input sample.
- R4: The product sample×gain (a 26-bit signed value) is shifted right by 10 bits with floor rounding. For example, sample -1 with gain 0x001 gives -1, and sample -3 with gain 0x200 gives -2.
- R5: `offsetIn` is a 14-bit two's-complement value added to the scaled product, so `dataOut` = floor(sample×gain/1024) + offset.
- R6: A result above +8191 is output as +8191 (code 0x1FFF).
- R7: A result below -8192 is output as -8192 (code 0x2000).
- R8: Negative gain codes scale with the correct sign: 0xC00 is -1 and 0x800 is -2. Sample -8192 at gain -2 clamps to +8191.
- R9: In cycles where no sample completes, `dataOut` holds its last value, whatever the inputs do meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Sample qualifier |
| sampleIn | input | 14 | Input sample, two's complement |
| gainCode | input | 12 | Gain, two's complement, 0x400 = unity |
| offsetIn | input | 14 | Offset, two's complement |
| validOut | output | 1 | Output qualifier, two cycles after `validIn` |
| dataOut | output | 14 | Scaled, offset and clamped sample |

## Verification
Each stage register is visible at the ports two edges after the sample that loads it. A wrong product or offset capture shows as a wrong `dataOut` two cycles after the faulty input. A stuck or leaking valid bit shows as `validOut` high in a cycle where the reference expects it low, or the reverse. A sign-extension or clamp fault only shows at specific codes: floor rounding of small negative products, the largest negative sample at gain -2, and sums just past either limit. The directed cases target those codes, and a random back-to-back stream compares every cycle.

// File: rtl/goc_pkg.sv
package goc_pkg;
  parameter int SAMPLE_W = 14;
  parameter int GAIN_W   = 12;
  parameter int FRAC_W   = 10;
  parameter int OFFSET_W = 14;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load product and offset into stage one
    logic commit;   // load clamped result into output register
  } gocStrobe_t;
endpackage

// File: rtl/goc_ctrl.sv
module goc_ctrl
  import goc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  output gocStrobe_t strobe,
  output logic       validOut
);
  logic s1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      validOut <= 1'b0;
    end else begin
      s1Valid  <= validIn;
      validOut <= s1Valid;
    end
  end

  always_comb begin
    strobe.capture = validIn;
    strobe.commit  = s1Valid;
  end

  // R2: each accepted sample moves one stage per clock
  a_r2_capture_to_commit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> strobe.commit);
  a_r2_commit_to_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> validOut);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> !validOut);
endmodule

// File: rtl/goc_datapath.sv
module goc_datapath
  import goc_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int GW = GAIN_W,
  parameter int FW = FRAC_W,
  parameter int OW = OFFSET_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gocStrobe_t           strobe,
  input  logic signed [SW-1:0] sampleIn,
  input  logic signed [GW-1:0] gainCode,
  input  logic signed [OW-1:0] offsetIn,
  output logic signed [SW-1:0] dataOut
);
  localparam int PROD_W  = SW + GW;
  localparam int SHIFT_W = PROD_W - FW;
  localparam int SUM_W   = ((SHIFT_W > OW) ? SHIFT_W : OW) + 1;
  localparam int MAX_I   = (2 ** (SW - 1)) - 1;
  localparam int MIN_I   = -(2 ** (SW - 1));
  localparam logic signed [SUM_W-1:0] MAX_S = $signed(SUM_W'(MAX_I));
  localparam logic signed [SUM_W-1:0] MIN_S = $signed(SUM_W'(MIN_I));

  logic signed [PROD_W-1:0]  prodNext;
  logic signed [PROD_W-1:0]  prodQ;
  logic signed [OW-1:0]      offQ;
  logic signed [SHIFT_W-1:0] scaled;
  logic signed [SUM_W-1:0]   sumWide;
  logic signed [SW-1:0]      clampNext;

  // Stage one: full-precision product
  assign prodNext = PROD_W'(sampleIn) * PROD_W'(gainCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ <= '0;
      offQ  <= '0;
    end else if (strobe.capture) begin
      prodQ <= prodNext;
      offQ  <= offsetIn;
    end
  end

  // Stage two: floor shift, offset add, clamp
  assign scaled  = prodQ[PROD_W-1:FW];
  assign sumWide = SUM_W'(scaled) + SUM_W'(offQ);

  generate
    if (SUM_W > SW) begin : g_clamp
      always_comb begin
        if (sumWide > MAX_S)      clampNext = SW'(MAX_I);
        else if (sumWide < MIN_S) clampNext = SW'(MIN_I);
        else                      clampNext = sumWide[SW-1:0];
      end
    end else begin : g_pass
      assign clampNext = SW'(sumWide);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataOut <= '0;
    else if (strobe.commit) dataOut <= clampNext;
  end

  // R9: output register holds while nothing completes
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(dataOut));
  // R6: overrange sums leave as positive full scale
  a_r6_clip_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && (sumWide > MAX_S)) |=> (dataOut == SW'(MAX_I)));
  // R7: underrange sums leave as negative full scale
  a_r7_clip_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && (sumWide < MIN_S)) |=> (dataOut == SW'(MIN_I)));
endmodule

// File: rtl/gain_offset_clamp.sv
module gain_offset_clamp
  import goc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                validIn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [GAIN_W-1:0]   gainCode,
  input  logic [OFFSET_W-1:0] offsetIn,
  output logic                validOut,
  output logic [SAMPLE_W-1:0] dataOut
);
  gocStrobe_t strobe;

  goc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  goc_datapath #(
    .SW (SAMPLE_W),
    .GW (GAIN_W),
    .FW (FRAC_W),
    .OW (OFFSET_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sampleIn (sampleIn),
    .gainCode (gainCode),
    .offsetIn (offsetIn),
    .dataOut  (dataOut)
  );
endmodule

// File: tb/gain_offset_clamp_tb.sv
module gain_offset_clamp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [13:0] sampleIn = '0;
  logic [11:0] gainCode = 12'h400;
  logic [13:0] offsetIn = '0;
  logic        validOut;
  logic [13:0] dataOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  bit m1Valid = 0;
  int m1Data  = 0;
  bit expValid = 0;
  int expData  = 0;

  gain_offset_clamp u_dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .sampleIn(sampleIn),
    .gainCode(gainCode), .offsetIn(offsetIn), .validOut(validOut), .dataOut(dataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int refCalc(logic [13:0] s, logic [11:0] g, logic [13:0] o);
    int p;
    int r;
    p = int'($signed(s)) * int'($signed(g));
    r = (p >>> 10) + int'($signed(o));
    if (r > 8191)  r = 8191;
    if (r < -8192) r = -8192;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m1Valid  <= 0;
      expValid <= 0;
      expData  <= 0;
    end else begin
      m1Valid <= validIn;
      if (validIn) m1Data <= refCalc(sampleIn, gainCode, offsetIn);
      expValid <= m1Valid;
      if (m1Valid) expData <= m1Data;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (validOut !== expValid || int'($signed(dataOut)) != expData) begin
        errors++;
        $display("FAIL R2 R9 stream: valid=%0b data=%0d expected valid=%0b data=%0d",
                 validOut, $signed(dataOut), expValid, expData);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one isolated sample, checked for latency and value
  task automatic one(string req, int s, int g, int o, int exp);
    @(negedge clk);
    sampleIn = 14'(s); gainCode = 12'(g); offsetIn = 14'(o); validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    check("R2 early", int'(validOut), 0);
    @(negedge clk);
    check("R2 valid", int'(validOut), 1);
    check(req, int'($signed(dataOut)), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(validOut), 0);
    check("R1 data in reset", int'(dataOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(validOut), 0);
    check("R1 data after reset", int'(dataOut), 0);

    one("R3 unity pos", 1234, 12'h400, 0, 1234);
    one("R3 unity neg", -5000, 12'h400, 0, -5000);
    one("R4 floor -1", -1, 12'h001, 0, -1);
    one("R4 floor +small", 1, 12'h001, 0, 0);
    one("R4 half pos", 3, 12'h200, 0, 1);
    one("R4 half neg", -3, 12'h200, 0, -2);
    one("R5 offset", 100, 12'h400, -300, -200);
    one("R6 offset overflow", 8000, 12'h400, 500, 8191);
    one("R6 gain overflow", 5000, 12'h7FF, 0, 8191);
    one("R7 underflow", -8000, 12'h400, -500, -8192);
    one("R8 minus one", 1000, 12'hC00, 0, -1000);
    one("R8 minus two", 4000, 12'h800, 0, -8000);
    one("R8 corner", -8192, 12'h800, 0, 8191);

    // R9: inputs change without validIn, output holds
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sampleIn = 14'(i * 977); gainCode = 12'h7FF; offsetIn = 14'h1000;
      check("R9 hold value", int'($signed(dataOut)), 8191);
      check("R9 hold valid", int'(validOut), 0);
    end

    // R2: back-to-back random stream, compared every clock by the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      validIn  = ($urandom_range(0, 3) != 0);
      sampleIn = 14'($urandom);
      gainCode = 12'($urandom);
      offsetIn = (i % 5 == 0) ? 14'($urandom) : 14'($urandom_range(0, 63));
    end
    @(negedge clk);
    validIn = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule